// File: doc/BRIEF.md
# CAS Signaling Change Flags

This block keeps the outgoing channel-associated signaling (CAS) tables for a circuit-emulation receiver and records which tables have changed. It holds eight signaling blocks. Each block is a row of 4-bit signaling nibbles, 24 by default. The receive path presents one strobe for each cell that carries signaling. With it come the index of the block that the channel points at and the nibbles the cell delivered. The block stores the new nibbles in every case. When the core-modify mode is on and the new nibbles differ from the stored ones, it also marks that block in a sticky status word.

Software polls the 16-bit status word and clears flags by writing ones to their positions. The interrupt output pulses only when a flag moves from clean to dirty. Further changes to a block whose flag is still set update the stored signaling without another pulse. A read port returns the stored nibbles of any block, so the transmit side can fetch the current signaling. A parameter selects a level-type interrupt instead, which is the OR of all flags.

Top module: `cas_sticky_status`

## Requirements
- R1: `statusReg` is 16 bits wide. Bits 7..0 always read 0. The flag for block b sits at bit 15-b, so block 0 is bit 15 and block 7 is bit 8.
- R2: A cell with `modifyEn`=1 whose nibbles differ from the stored ones in at least one position sets the flag of its block. The flag is visible in the cycle after the strobe.
- R3: With `modifyEn`=0, a cell sets no flag and raises no interrupt. Its nibbles are still written to the block.
- R4: A set flag stays set until software clears it. A write with `swClearValid`=1 clears, in the next cycle, each flag whose bit in `swClearMask` is 1 (same bit layout as R1). Mask bits that are 0 have no effect.
- R5: `irqPulse` is high for exactly one cycle, the cycle after a cell that moves a flag from clear to set. It is low at all other times.
- R6: A changed cell for a block whose flag is already set updates the stored nibbles and produces no interrupt.
- R7: A cell whose nibbles equal the stored ones sets no flag and raises no interrupt. The identical data is rewritten.
- R8: When a clear of a block's flag and a set of that flag fall in the same cycle, the flag ends set and `irqPulse` fires.
- R9: `rdNibbles` returns the stored nibbles of block `rdBlock`, with nibble k at bits 4k+3..4k. A write becomes readable in the cycle after the strobe.
- R10: After reset, all flags, all stored nibbles and `irqPulse` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellValid | input | 1 | One cell with signaling is presented this cycle |
| cellBlock | input | 3 | Signaling block selected by the cell's channel |
| cellNibbles | input | 96 | Received signaling nibbles, nibble k at bits 4k+3..4k |
| modifyEn | input | 1 | Core-modify mode: enables flag setting and interrupts |
| swClearValid | input | 1 | Software write-one-to-clear strobe |
| swClearMask | input | 16 | Bits to clear, in the status word layout |
| rdBlock | input | 3 | Block whose stored nibbles are read |
| rdNibbles | output | 96 | Stored nibbles of `rdBlock` |
| statusReg | output | 16 | Sticky change flags |
| irqPulse | output | 1 | Change interrupt |

## Verification
A wrong stored row shows on `rdNibbles` one cycle after the faulty write. It also shows on the next cell for that block: the flag and the interrupt then fire or stay quiet wrongly in the cycle after that strobe. A lost or stray flag appears on `statusReg` in the cycle after the triggering cell or clear. A flag that fails to clear leads to a missing interrupt on the next change to that block. The reference model compares all three outputs on every clock, so each of these faults is reported within two cycles of the stimulus that exposes it.

// File: rtl/cas_sticky_pkg.sv
package cas_sticky_pkg;

  // Strobes from the flag control to the signaling store
  typedef struct packed {
    logic wrEn;     // write the cell nibbles into the selected block
    logic setFlag;  // the cell changed the block while modify mode is on
    logic fireIrq;  // the flag goes from clean to dirty this cycle
  } casStrobe_t;

endpackage

// File: rtl/cas_store_dp.sv
module cas_store_dp
  import cas_sticky_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int NIBBLES    = 24,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int DATA_W = NIBBLES * 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  casStrobe_t        strobe,
  input  logic [BLK_W-1:0]  cellBlock,
  input  logic [DATA_W-1:0] cellNibbles,
  input  logic [BLK_W-1:0]  rdBlock,
  output logic              dataDiffers,
  output logic [DATA_W-1:0] rdNibbles
);

  logic [DATA_W-1:0]   blockQ [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] blockWr;
  logic [DATA_W-1:0]   curRow;
  logic [NIBBLES-1:0]  nibMismatch;

  // One register row per signaling block, each with its own write enable
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_row
    assign blockWr[b] = strobe.wrEn && (cellBlock == BLK_W'(b));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        blockQ[b] <= '0;
      end else if (blockWr[b]) begin
        blockQ[b] <= cellNibbles;
      end
    end
  end

  always_comb begin
    curRow = '0;
    if (int'(cellBlock) < NUM_BLOCKS) curRow = blockQ[cellBlock];
  end

  // Nibble-wise compare, reduced to one change bit
  for (genvar k = 0; k < NIBBLES; k++) begin : g_cmp
    assign nibMismatch[k] = curRow[4*k +: 4] != cellNibbles[4*k +: 4];
  end
  assign dataDiffers = |nibMismatch;

  always_comb begin
    rdNibbles = '0;
    if (int'(rdBlock) < NUM_BLOCKS) rdNibbles = blockQ[rdBlock];
  end

endmodule

// File: rtl/cas_flag_ctrl.sv
module cas_flag_ctrl
  import cas_sticky_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int STATUS_W   = 16,
  parameter bit IRQ_LEVEL  = 1'b0,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int RSV_W = STATUS_W - NUM_BLOCKS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cellValid,
  input  logic [BLK_W-1:0]    cellBlock,
  input  logic                modifyEn,
  input  logic                dataDiffers,
  input  logic                swClearValid,
  input  logic [STATUS_W-1:0] swClearMask,
  output casStrobe_t          strobe,
  output logic [STATUS_W-1:0] statusReg,
  output logic                irqOut
);

  logic [NUM_BLOCKS-1:0] flagQ, flagD;
  logic [NUM_BLOCKS-1:0] selVec, setVec, clrVec;
  logic                  curFlag, curClr;

  // Block decode and per-block clear taken from the status layout
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_dec
    assign selVec[b] = cellBlock == BLK_W'(b);
    assign clrVec[b] = swClearValid && swClearMask[RSV_W + NUM_BLOCKS - 1 - b];
  end

  assign curFlag = |(flagQ & selVec);
  assign curClr  = |(clrVec & selVec);

  always_comb begin
    strobe.wrEn    = cellValid;
    strobe.setFlag = cellValid && modifyEn && dataDiffers;
    strobe.fireIrq = strobe.setFlag && (!curFlag || curClr);
  end

  assign setVec = strobe.setFlag ? selVec : '0;
  // A hardware set wins over a same-cycle software clear
  assign flagD  = (flagQ & ~clrVec) | setVec;

  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagD;
  end

  // Status word: reserved low bits, block 0 at the top bit
  for (genvar i = 0; i < STATUS_W; i++) begin : g_stat
    if (i < RSV_W) begin : g_rsv
      assign statusReg[i] = 1'b0;
    end else begin : g_flag
      assign statusReg[i] = flagQ[RSV_W + NUM_BLOCKS - 1 - i];
    end
  end

  if (IRQ_LEVEL) begin : g_irq_level
    assign irqOut = |flagQ;
  end else begin : g_irq_pulse
    logic irqQ;
    always_ff @(posedge clk) begin
      if (!rstN) irqQ <= 1'b0;
      else       irqQ <= strobe.fireIrq;
    end
    assign irqOut = irqQ;
  end

endmodule

// File: rtl/cas_sticky_status.sv
module cas_sticky_status
  import cas_sticky_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int NIBBLES    = 24,
  parameter int STATUS_W   = 16,
  parameter bit IRQ_LEVEL  = 1'b0,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int DATA_W = NIBBLES * 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cellValid,
  input  logic [BLK_W-1:0]    cellBlock,
  input  logic [DATA_W-1:0]   cellNibbles,
  input  logic                modifyEn,
  input  logic                swClearValid,
  input  logic [STATUS_W-1:0] swClearMask,
  input  logic [BLK_W-1:0]    rdBlock,
  output logic [DATA_W-1:0]   rdNibbles,
  output logic [STATUS_W-1:0] statusReg,
  output logic                irqPulse
);

  casStrobe_t strobe;
  logic       dataDiffers;

  cas_store_dp #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .NIBBLES   (NIBBLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cellBlock  (cellBlock),
    .cellNibbles(cellNibbles),
    .rdBlock    (rdBlock),
    .dataDiffers(dataDiffers),
    .rdNibbles  (rdNibbles)
  );

  cas_flag_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .STATUS_W  (STATUS_W),
    .IRQ_LEVEL (IRQ_LEVEL)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cellValid   (cellValid),
    .cellBlock   (cellBlock),
    .modifyEn    (modifyEn),
    .dataDiffers (dataDiffers),
    .swClearValid(swClearValid),
    .swClearMask (swClearMask),
    .strobe      (strobe),
    .statusReg   (statusReg),
    .irqOut      (irqPulse)
  );

endmodule

// File: rtl/cas_sticky_status_chk.sv
module cas_sticky_status_chk #(
  parameter int NUM_BLOCKS = 8,
  parameter int STATUS_W   = 16,
  parameter bit IRQ_LEVEL  = 1'b0,
  localparam int RSV_W = STATUS_W - NUM_BLOCKS
) (
  input logic                clk,
  input logic                rstN,
  input logic                cellValid,
  input logic                modifyEn,
  input logic                swClearValid,
  input logic [STATUS_W-1:0] statusReg,
  input logic                irqPulse
);

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[RSV_W-1:0] == '0); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !swClearValid |=> (($past(statusReg) & ~statusReg) == '0)); // R4

  AST_NO_SET_WITHOUT_MODE: assert property (@(posedge clk) disable iff (!rstN)
    !(cellValid && modifyEn) |=> ((statusReg & ~$past(statusReg)) == '0)); // R3

  if (!IRQ_LEVEL) begin : g_pulse_chk
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqPulse) |-> $past(cellValid && modifyEn)); // R5

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
      irqPulse |=> !irqPulse || $past(cellValid && modifyEn)); // R5

    AST_IRQ_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
      irqPulse |-> statusReg != '0); // R2
  end

endmodule

bind cas_sticky_status cas_sticky_status_chk #(
  .NUM_BLOCKS(NUM_BLOCKS),
  .STATUS_W  (STATUS_W),
  .IRQ_LEVEL (IRQ_LEVEL)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cellValid   (cellValid),
  .modifyEn    (modifyEn),
  .swClearValid(swClearValid),
  .statusReg   (statusReg),
  .irqPulse    (irqPulse)
);

// File: tb/cas_sticky_status_bench.sv
module cas_sticky_status_bench;

  localparam int NB = 8;
  localparam int NN = 24;
  localparam int DW = NN * 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cellValid = 1'b0;
  logic [2:0]    cellBlock = '0;
  logic [DW-1:0] cellNibbles = '0;
  logic          modifyEn = 1'b0;
  logic          swClearValid = 1'b0;
  logic [15:0]   swClearMask = '0;
  logic [2:0]    rdBlock = '0;
  logic [DW-1:0] rdNibbles;
  logic [15:0]   statusReg;
  logic          irqPulse;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // Reference model state
  logic [DW-1:0] mRow [NB];
  bit            mFlag [NB];
  bit            mIrq;

  always #2.5 clk = ~clk;

  cas_sticky_status u_cas_sticky_status (
    .clk(clk), .rstN(rstN), .cellValid(cellValid), .cellBlock(cellBlock),
    .cellNibbles(cellNibbles), .modifyEn(modifyEn), .swClearValid(swClearValid),
    .swClearMask(swClearMask), .rdBlock(rdBlock), .rdNibbles(rdNibbles),
    .statusReg(statusReg), .irqPulse(irqPulse)
  );

  function automatic logic [15:0] expStatus();
    logic [15:0] s = '0;
    for (int b = 0; b < NB; b++) s[15 - b] = mFlag[b];
    return s;
  endfunction

  // Behavioural model, updated at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NB; b++) begin mRow[b] = '0; mFlag[b] = 0; end
      mIrq = 0;
    end else begin
      bit change, clrHit;
      int blk;
      blk = int'(cellBlock);
      mIrq = 0;
      change = cellValid && modifyEn && (mRow[blk] != cellNibbles);
      clrHit = swClearValid && swClearMask[15 - blk];
      if (change && (!mFlag[blk] || clrHit)) mIrq = 1;
      for (int b = 0; b < NB; b++)
        if (swClearValid && swClearMask[15 - b]) mFlag[b] = 0;
      if (change) mFlag[blk] = 1;
      if (cellValid) mRow[blk] = cellNibbles;
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      cycles++;
      check(statusReg == expStatus(), "R1/R2 status", 128'(statusReg), 128'(expStatus()));
      check(irqPulse == mIrq, "R5 irq", 128'(irqPulse), 128'(mIrq));
      check(rdNibbles == mRow[rdBlock], "R9 readback", 128'(rdNibbles), 128'(mRow[rdBlock]));
    end
  end

  task automatic sendCell(input int blk, input logic [DW-1:0] d, input bit mode,
                          input bit clr, input logic [15:0] mask);
    @(negedge clk); #1;
    cellValid = 1'b1; cellBlock = 3'(blk); cellNibbles = d; modifyEn = mode;
    swClearValid = clr; swClearMask = mask; rdBlock = 3'(blk);
    @(negedge clk); #1;
    cellValid = 1'b0; swClearValid = 1'b0; swClearMask = '0;
  endtask

  task automatic swClear(input logic [15:0] mask);
    @(negedge clk); #1;
    swClearValid = 1'b1; swClearMask = mask;
    @(negedge clk); #1;
    swClearValid = 1'b0; swClearMask = '0;
  endtask

  function automatic logic [DW-1:0] pattern(input int seed);
    logic [DW-1:0] p = '0;
    for (int k = 0; k < NN; k++) p[4*k +: 4] = 4'((seed + 3 * k) & 15);
    return p;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    // R10: reset state
    check(statusReg == 16'h0 && irqPulse == 1'b0, "R10 reset", 128'(statusReg), 128'(0));
    check(rdNibbles == '0, "R10 reset rows", 128'(rdNibbles), 128'(0));

    // R2, R5: clean block 2 changes
    sendCell(2, pattern(1), 1, 0, '0);
    check(statusReg == 16'h2000, "R2 flag bit 13", 128'(statusReg), 128'(16'h2000));
    check(irqPulse == 1'b1, "R5 pulse", 128'(irqPulse), 128'(1));
    @(negedge clk); #1;
    check(irqPulse == 1'b0, "R5 one cycle", 128'(irqPulse), 128'(0));

    // R6: change again while flagged
    sendCell(2, pattern(7), 1, 0, '0);
    check(irqPulse == 1'b0, "R6 no second irq", 128'(irqPulse), 128'(0));
    check(rdNibbles == pattern(7), "R6 row updated", 128'(rdNibbles), 128'(pattern(7)));

    // R7: identical data to clean block 0 (zero after reset)
    sendCell(0, '0, 1, 0, '0);
    check(statusReg == 16'h2000 && !irqPulse, "R7 identical", 128'(statusReg), 128'(16'h2000));

    // R3: mode off, block 3 changes
    sendCell(3, pattern(4), 0, 0, '0);
    check(statusReg == 16'h2000 && !irqPulse, "R3 mode off", 128'(statusReg), 128'(16'h2000));
    check(rdNibbles == pattern(4), "R3 row written", 128'(rdNibbles), 128'(pattern(4)));

    // R4: zero mask, then clear block 2
    swClear(16'h00FF);
    check(statusReg == 16'h2000, "R4 zero mask bits", 128'(statusReg), 128'(16'h2000));
    swClear(16'h2000);
    check(statusReg == 16'h0, "R4 w1c", 128'(statusReg), 128'(0));

    // R1: block 7 maps to bit 8, block 0 to bit 15
    sendCell(7, pattern(2), 1, 0, '0);
    sendCell(0, pattern(3), 1, 0, '0);
    check(statusReg == 16'h8100, "R1 bit layout", 128'(statusReg), 128'(16'h8100));

    // R8: set and clear of block 7 in one cycle
    sendCell(7, pattern(9), 1, 1, 16'h0100);
    check(statusReg == 16'h8100 && irqPulse, "R8 set wins", 128'({irqPulse, statusReg}),
          128'({1'b1, 16'h8100}));

    // Mixed traffic, checked every cycle against the model
    for (int n = 0; n < 400; n++) begin
      logic [DW-1:0] d;
      d = '0;
      for (int k = 0; k < NN; k++) d[4*k] = 1'($urandom_range(0, 1) & ($urandom_range(0, 3) == 0));
      @(negedge clk); #1;
      cellValid    = 1'($urandom_range(0, 2) != 0);
      cellBlock    = 3'($urandom_range(0, 7));
      cellNibbles  = d;
      modifyEn     = 1'($urandom_range(0, 3) != 0);
      swClearValid = 1'($urandom_range(0, 3) == 0);
      swClearMask  = 16'($urandom_range(0, 65535));
      rdBlock      = 3'($urandom_range(0, 7));
    end
    @(negedge clk); #1;
    cellValid = 1'b0; swClearValid = 1'b0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule